// File: doc/BRIEF.md
# Automatic XON/XOFF Flow Controller

This block watches the stream of characters arriving at a serial receiver and looks for software flow-control codes programmed by the host. When the remote side asks the local end to stop, the block raises a transmit-halt flag that the local transmitter obeys. The halt only takes hold at a transmitter character boundary, so a character already on the wire is never cut short. When the remote side asks for resumption, the halt is dropped. Every stop request also sets a sticky interrupt flag, which the host clears with a read strobe.

Four character registers are supplied as inputs: two resume codes and two stop codes. A 4-bit mode input picks how they are used. The block can match a single character from the first pair, a single character from the second pair, or a two-character sequence in which the second code must arrive directly after the first. A received byte that completes a match is flagged as consumed in the same cycle, so the receive path can keep it out of its buffer.

Top module: `sfc_xonxoff_ctrl`

## Requirements
- R1: After reset, tx_halt and xoff_irq are low, and rx_consumed is low in every cycle where rx_valid is low.
- R2: After a stop match, tx_halt goes high on the clock edge that samples tx_boundary high, and not before. A boundary in the same cycle as the matching byte counts. The halt then stays high until it is released.
- R3: mode[1:0] selects the receive match: 00 = off, 01 = single character using xon_a/xoff_a, 10 = single character using xon_b/xoff_b, 11 = pair, meaning xon_a then xon_b, or xoff_a then xoff_b. Codes from the set that is not selected are not matched.
- R4: A resume match clears tx_halt on the next clock edge, with no boundary strobe needed. It also cancels a stop that is still waiting for a boundary.
- R5: rx_consumed is high, in the same cycle as rx_valid, exactly for a byte that completes a resume or stop match. In pair mode that is only the second byte.
- R6: xoff_irq goes high on the clock edge after a stop match and stays high until a cycle with irq_clr high. If a stop match and irq_clr fall in the same cycle, the flag is set.
- R7: While mode[1:0] is 00, nothing is matched, and tx_halt and any waiting stop are cleared on the next clock edge.
- R8: mode[3:2] has no effect on matching, consumption or halting.
- R9: In pair mode, the second code must be the very next received byte. Any other byte cancels the partial match. A byte equal to a first code arms a new partial match.
- R10: When one byte matches both a stop and a resume code, it is treated as a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on rx_data |
| rx_data | input | DATA_W | Received character |
| xon_a | input | DATA_W | First resume code |
| xon_b | input | DATA_W | Second resume code |
| xoff_a | input | DATA_W | First stop code |
| xoff_b | input | DATA_W | Second stop code |
| mode | input | 4 | Match mode; bits [1:0] per R3, bits [3:2] unused by this block |
| tx_boundary | input | 1 | Transmitter has finished a character |
| irq_clr | input | 1 | Read strobe that clears xoff_irq |
| tx_halt | output | 1 | Transmitter must not start a new character |
| xoff_irq | output | 1 | Sticky stop-received flag |
| rx_consumed | output | 1 | Current received byte is a completing flow-control code |

## Verification
The bench builds the block with its default DATA_W of 8. At that width the code registers can be set equal to each other, which exercises the stop-over-resume priority, and distinct codes can be interleaved to break and re-arm a pair. The bench also times the boundary strobe against the matching byte. It places the strobe both in the same cycle and in later cycles, which shows whether the halt waits for the character edge or comes early.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [1:0] {
    SEL_OFF  = 2'b00,
    SEL_SET1 = 2'b01,
    SEL_SET2 = 2'b10,
    SEL_PAIR = 2'b11
  } sel_e;

  // Decode the full mode word; only the low two bits choose the match style.
  function automatic sel_e decode_sel(input logic [3:0] m);
    sel_e s;
    casez (m)
      4'b??01: s = SEL_SET1;
      4'b??10: s = SEL_SET2;
      4'b??11: s = SEL_PAIR;
      default: s = SEL_OFF;
    endcase
    return s;
  endfunction

  // A stop hit beats a resume hit on the same byte.
  function automatic logic resume_wins(input logic on_raw, input logic off_raw);
    return on_raw && !off_raw;
  endfunction

endpackage

// File: rtl/sfc_matcher.sv
module sfc_matcher
  import sfc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W-1:0] xon_a,
  input  logic [DATA_W-1:0] xon_b,
  input  logic [DATA_W-1:0] xoff_a,
  input  logic [DATA_W-1:0] xoff_b,
  input  sel_e              sel,
  output logic              xon_hit,
  output logic              xoff_hit
);

  logic arm_on, arm_off;
  logic on_raw, off_raw;
  logic eq_on_a, eq_on_b, eq_off_a, eq_off_b;

  assign eq_on_a  = (rx_data == xon_a);
  assign eq_on_b  = (rx_data == xon_b);
  assign eq_off_a = (rx_data == xoff_a);
  assign eq_off_b = (rx_data == xoff_b);

  always_comb begin
    on_raw  = 1'b0;
    off_raw = 1'b0;
    unique case (sel)
      SEL_SET1: begin on_raw = eq_on_a;          off_raw = eq_off_a;          end
      SEL_SET2: begin on_raw = eq_on_b;          off_raw = eq_off_b;          end
      SEL_PAIR: begin on_raw = arm_on && eq_on_b; off_raw = arm_off && eq_off_b; end
      default:  begin on_raw = 1'b0;             off_raw = 1'b0;              end
    endcase
  end

  assign xoff_hit = rx_valid && off_raw;
  assign xon_hit  = rx_valid && resume_wins(on_raw, off_raw);

  // Partial-match state for pair mode: any byte either completes,
  // re-arms, or cancels the partial match.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_on  <= 1'b0;
      arm_off <= 1'b0;
    end else if (sel != SEL_PAIR) begin
      arm_on  <= 1'b0;
      arm_off <= 1'b0;
    end else if (rx_valid) begin
      if (on_raw || off_raw) begin
        arm_on  <= 1'b0;
        arm_off <= 1'b0;
      end else begin
        arm_on  <= eq_on_a;
        arm_off <= eq_off_a;
      end
    end
  end

  a_r10_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    !(xon_hit && xoff_hit));

  a_r9_no_arm_outside_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != SEL_PAIR) |=> !(arm_on || arm_off) || (sel == SEL_PAIR));

endmodule

// File: rtl/sfc_halt_ctrl.sv
module sfc_halt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic xon_hit,
  input  logic xoff_hit,
  input  logic tx_boundary,
  input  logic irq_clr,
  output logic tx_halt,
  output logic xoff_irq
);

  logic stop_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_wait <= 1'b0;
      tx_halt   <= 1'b0;
    end else if (!enable || xon_hit) begin
      stop_wait <= 1'b0;
      tx_halt   <= 1'b0;
    end else begin
      if (xoff_hit)
        stop_wait <= 1'b1;
      if (tx_boundary && (stop_wait || xoff_hit))
        tx_halt <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      xoff_irq <= 1'b0;
    else if (xoff_hit)
      xoff_irq <= 1'b1;
    else if (irq_clr)
      xoff_irq <= 1'b0;
  end

  a_r2_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_halt) |-> $past(tx_boundary));

  a_r4_resume_clears: assert property (@(posedge clk) disable iff (!rst_n)
    xon_hit |=> !tx_halt);

  a_r6_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_hit |=> xoff_irq);

  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (xoff_irq && !irq_clr) |=> xoff_irq);

  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !tx_halt);

endmodule

// File: rtl/sfc_xonxoff_ctrl.sv
module sfc_xonxoff_ctrl
  import sfc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W-1:0] xon_a,
  input  logic [DATA_W-1:0] xon_b,
  input  logic [DATA_W-1:0] xoff_a,
  input  logic [DATA_W-1:0] xoff_b,
  input  logic [3:0]        mode,
  input  logic              tx_boundary,
  input  logic              irq_clr,
  output logic              tx_halt,
  output logic              xoff_irq,
  output logic              rx_consumed
);

  sel_e sel;
  logic enable;
  logic xon_hit, xoff_hit;

  always_comb sel = decode_sel(mode);
  assign enable = (sel != SEL_OFF);

  sfc_matcher #(.DATA_W(DATA_W)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .xon_a    (xon_a),
    .xon_b    (xon_b),
    .xoff_a   (xoff_a),
    .xoff_b   (xoff_b),
    .sel      (sel),
    .xon_hit  (xon_hit),
    .xoff_hit (xoff_hit)
  );

  sfc_halt_ctrl u_halt (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .xon_hit     (xon_hit),
    .xoff_hit    (xoff_hit),
    .tx_boundary (tx_boundary),
    .irq_clr     (irq_clr),
    .tx_halt     (tx_halt),
    .xoff_irq    (xoff_irq)
  );

  assign rx_consumed = xon_hit || xoff_hit;

  a_r5_consume_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_consumed |-> rx_valid);

endmodule

// File: tb/sfc_xonxoff_ctrl_test.sv
`timescale 1ns/1ps
module sfc_xonxoff_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [7:0] xon_a = 8'h11, xon_b = 8'hA1, xoff_a = 8'h13, xoff_b = 8'hA3;
  logic [3:0] mode = 4'b0000;
  logic       tx_boundary = 1'b0;
  logic       irq_clr = 1'b0;
  logic       tx_halt, xoff_irq, rx_consumed;

  int checks = 0;
  int fails = 0;
  bit exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  sfc_xonxoff_ctrl uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .xon_a(xon_a), .xon_b(xon_b), .xoff_a(xoff_a), .xoff_b(xoff_b),
    .mode(mode), .tx_boundary(tx_boundary), .irq_clr(irq_clr),
    .tx_halt(tx_halt), .xoff_irq(xoff_irq), .rx_consumed(rx_consumed)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // Monitor: mid-cycle, pop the expected consumption flag for each byte.
  always @(negedge clk) begin
    #5;
    if (rx_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R5: actual unexpected byte expected none");
      end else begin
        check(rx_consumed, exp_q.pop_front(), tag_q.pop_front());
      end
    end else if (rst_n) begin
      check(rx_consumed, 1'b0, "R1 idle consumed");
    end
  end

  // Driver: one byte per call, optional boundary or clear in the same cycle.
  task automatic send(input logic [7:0] b, input bit exp, input string tag,
                      input bit bnd = 1'b0, input bit clr = 1'b0);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; tx_boundary = bnd; irq_clr = clr;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rx_valid = 1'b0; tx_boundary = 1'b0; irq_clr = 1'b0;
    #1;
  endtask

  task automatic boundary();
    @(negedge clk); tx_boundary = 1'b1;
    @(negedge clk); tx_boundary = 1'b0; #1;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0; #1;
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk); mode = m;
    @(negedge clk); #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(tx_halt, 1'b0, "R1 reset halt");
    check(xoff_irq, 1'b0, "R1 reset irq");
    rst_n = 1'b1;
    set_mode(4'b0001);

    send(8'h41, 1'b0, "R5 plain byte");
    check(tx_halt, 1'b0, "R1 halt after plain");
    send(8'h13, 1'b1, "R5 xoff_a consumed");
    check(tx_halt, 1'b0, "R2 no halt before boundary");
    check(xoff_irq, 1'b1, "R6 irq set");
    repeat (3) @(negedge clk);
    #1 check(tx_halt, 1'b0, "R2 still waiting");
    boundary();
    check(tx_halt, 1'b1, "R2 halt at boundary");
    send(8'h11, 1'b1, "R4 xon_a consumed");
    check(tx_halt, 1'b0, "R4 resume");
    check(xoff_irq, 1'b1, "R6 sticky");
    clear_irq();
    check(xoff_irq, 1'b0, "R6 cleared");

    // R4: resume cancels a waiting stop
    send(8'h13, 1'b1, "R5 xoff again");
    send(8'h11, 1'b1, "R4 xon cancel");
    boundary();
    check(tx_halt, 1'b0, "R4 waiting stop cancelled");
    clear_irq();

    // R3: second set only
    set_mode(4'b0010);
    send(8'h13, 1'b0, "R3 set one ignored");
    check(xoff_irq, 1'b0, "R3 no irq from set one");
    send(8'hA3, 1'b1, "R3 xoff_b consumed");
    boundary();
    check(tx_halt, 1'b1, "R3 halt via set two");

    // R7: disable
    set_mode(4'b0000);
    check(tx_halt, 1'b0, "R7 disable clears halt");
    clear_irq();
    send(8'hA3, 1'b0, "R7 no match when off");
    check(xoff_irq, 1'b0, "R7 no irq when off");
    set_mode(4'b0010);
    boundary();
    check(tx_halt, 1'b0, "R7 waiting stop dropped");

    // R8 + R9: pair mode with upper bits set
    set_mode(4'b0111);
    send(8'h13, 1'b0, "R9 first of pair");
    send(8'h13, 1'b0, "R9 re-arm");
    send(8'hA3, 1'b1, "R9 pair completes");
    boundary();
    check(tx_halt, 1'b1, "R8 pair halt with upper bits");
    send(8'h11, 1'b0, "R9 xon first");
    send(8'h55, 1'b0, "R9 intervening byte");
    send(8'hA1, 1'b0, "R9 broken pair");
    check(tx_halt, 1'b0 ^ 1'b1, "R9 still halted");
    send(8'h11, 1'b0, "R9 xon first again");
    send(8'hA1, 1'b1, "R9 xon pair");
    check(tx_halt, 1'b0, "R9 resumed by pair");
    clear_irq();

    // R10: same code in both roles
    set_mode(4'b1101);
    xon_a = 8'h5A; xoff_a = 8'h5A;
    send(8'h5A, 1'b1, "R10 shared code");
    check(xoff_irq, 1'b1, "R10 stop wins irq");
    boundary();
    check(tx_halt, 1'b1, "R10 stop wins halt");
    xon_a = 8'h11;
    send(8'h11, 1'b1, "R4 xon after R10");
    check(tx_halt, 1'b0, "R4 resume after R10");

    // R2 boundary in same cycle; R6 set beats clear
    send(8'h5A, 1'b1, "R2 xoff with boundary", 1'b1, 1'b1);
    check(tx_halt, 1'b1, "R2 same-cycle boundary");
    check(xoff_irq, 1'b1, "R6 set beats clear");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule